// File: doc/BRIEF.md
# Two-Sided Mailbox with Doorbells

This block lets two processors, called side A and side B, pass 32-bit words and signal events to each other. Each side reaches its own register bank over a simple memory-mapped bus with a select, a write strobe, a byte address and a data word. Each side has four outbound data slots and four inbound data slots. A word that one side writes into outbound slot n appears in inbound slot n of the other side. A pair of flags per slot tells the writer when the slot has drained and tells the reader when it holds a word.

Each side can also ring four doorbells that carry no data. A doorbell raises a pending flag on the far side. The far side clears that flag by writing one to it, and the ringer's request bit then drops on its own. Each side has one level interrupt. It is built from its status flags, each masked by its own enable bit. Each side's status register also shows whether the other processor is held in reset.

In every per-channel field, channel n sits at bit (3 − n) of the field. Channel 0 therefore uses the highest bit of each field.

Top module: `msg_unit`

## Requirements
- R1: After reset both control registers read 0, both status registers read 0x00F00000 (every transmit-empty flag set, no full or pending flag), and both interrupts are low.
- R2: Writing outbound slot n (byte offset 4·n) on one side has two effects one cycle later. It clears that side's transmit-empty flag at status bit 20+(3−n). It sets the other side's receive-full flag at status bit 24+(3−n).
- R3: Reading inbound slot n (byte offset 0x10+4·n) returns the word last written by the other side. It clears the reader's receive-full flag n and sets the writer's transmit-empty flag n again.
- R4: If the writer stores into slot n in the same cycle that the reader reads it, the write wins. The read returns the older word, receive-full stays set and transmit-empty stays clear.
- R5: Writing an outbound slot that is still full replaces the word and leaves the flags unchanged. Reading an outbound slot returns the word last written to it.
- R6: Writing 1 to control bit 16+(3−n) (offset 0x24) rings doorbell n. The request bit reads back as 1, and the other side's pending flag at status bit 28+(3−n) (offset 0x20) is set. Writing 0 to a request bit does not withdraw the request.
- R7: Writing 1 to a pending bit in a side's status register clears it and clears the ringer's request bit. Writing 0 to it, or writing to any other status bit, changes nothing.
- R8: If a doorbell is rung in the same cycle that its pending flag is cleared, the flag stays set.
- R9: A side's interrupt goes high one cycle after any of its flags is set while its enable is set, and goes low one cycle after no such pair remains. Enable fields in the control register: doorbell enable n at bit 28+(3−n), receive enable n at bit 24+(3−n), transmit enable n at bit 20+(3−n).
- R10: The control enable bits read back as written. Control bits 15:0 always read 0.
- R11: Status bit 9 on one side reflects, one cycle later, the reset indication input of the other processor.
- R12: Reads at offsets above 0x24, or at addresses that are not word aligned, return 0. Read data appears one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 1 | Side A access select |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | ADDR_W | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, registered |
| a_irq | output | 1 | Side A interrupt, level |
| a_cpu_in_reset | input | 1 | Processor A held in reset, shown to side B |
| b_sel | input | 1 | Side B access select |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | ADDR_W | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, registered |
| b_irq | output | 1 | Side B interrupt, level |
| b_cpu_in_reset | input | 1 | Processor B held in reset, shown to side A |

## Verification
Data words are sent in both directions and on channels at both ends of the reversed field. This separates a correct bit placement from a mirrored one, and separates a swapped direction from a correct crossing. Overwriting a full slot, and a write that collides with a read, check which update wins on the flags and the returned word. Doorbells are rung, then acknowledged with zero, with non-doorbell bits and with the proper one. One doorbell is rung and cleared in the same cycle. These cases separate write-one-to-clear from plain writes and check the self-clearing request. Interrupts are driven from each of the three flag kinds through single enable bits, which checks the masking and the one-cycle output register.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int NCH      = 4;
  localparam int REG_W    = 32;
  localparam int IDX_TX   = 0;
  localparam int IDX_RX   = NCH;
  localparam int IDX_STAT = 2 * NCH;
  localparam int IDX_CTRL = 2 * NCH + 1;
  // positions inside the upper half-word (bits 31:16) of a write
  localparam int HI_BELL  = 12;
  localparam int HI_EN    = 4;
  localparam int HI_RING  = 0;
  localparam int EN_W     = 3 * NCH;

  function automatic logic [NCH-1:0] flip(input logic [NCH-1:0] v);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[NCH-1-i] = v[i];
    return r;
  endfunction
endpackage

// File: rtl/mu_link.sv
module mu_link #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] word,
  output logic         full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      full <= 1'b0;
    end else begin
      if (wr) word <= wdata;
      if (wr) full <= 1'b1;
      else if (rd) full <= 1'b0;
    end
  end

  // R2 and R4: a store always leaves the slot full
  p_store_fills_r2: assert property (@(posedge clk) disable iff (rst) wr |=> full);
  // R3: a read without a competing store drains the slot
  p_read_drains_r3: assert property (@(posedge clk) disable iff (rst) rd && !wr |=> !full);
  // R5: the word only changes on a store
  p_word_hold_r5: assert property (@(posedge clk) disable iff (rst) !wr |=> $stable(word));
endmodule

// File: rtl/mu_bell.sv
module mu_bell (
  input  logic clk,
  input  logic rst,
  input  logic ring,
  input  logic ack,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (ring) pend <= 1'b1;
    else if (ack)  pend <= 1'b0;
  end

  // R6 and R8: ringing wins over a clear in the same cycle
  p_ring_sets_r8: assert property (@(posedge clk) disable iff (rst) ring |=> pend);
  // R7: a clear without a ring drops the flag
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst) ack && !ring |=> !pend);
  // R6: nothing else moves the flag
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (rst) !ring && !ack |=> $stable(pend));
endmodule

// File: rtl/mu_side.sv
module mu_side
  import mu_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sel,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [15:0]                 wr_hi,
  output logic [REG_W-1:0]            rdata,
  output logic                        irq,
  input  logic                        peer_in_reset,
  output logic [NCH-1:0]              tx_wr,
  input  logic [NCH-1:0][REG_W-1:0]   tx_word,
  input  logic [NCH-1:0]              tx_full,
  output logic [NCH-1:0]              rx_rd,
  input  logic [NCH-1:0][REG_W-1:0]   rx_word,
  input  logic [NCH-1:0]              rx_full,
  output logic [NCH-1:0]              ring_out,
  input  logic [NCH-1:0]              ring_busy,
  output logic [NCH-1:0]              bell_ack,
  input  logic [NCH-1:0]              bell_pend
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0]    idx;
  logic             aligned, rd_en, wr_en, ctrl_wr, stat_wr;
  logic [EN_W-1:0]  en_q;
  logic             peer_q;
  logic [REG_W-1:0] stat_w, ctrl_w, rd_mux;
  logic [NCH-1:0]   te_f, rf_f, gp_f;
  logic             cause;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign rd_en   = sel && !wr && aligned;
  assign wr_en   = sel && wr && aligned;
  assign ctrl_wr = wr_en && (idx == IW'(IDX_CTRL));
  assign stat_wr = wr_en && (idx == IW'(IDX_STAT));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign tx_wr[n]    = wr_en && (idx == IW'(IDX_TX + n));
    assign rx_rd[n]    = rd_en && (idx == IW'(IDX_RX + n));
    assign ring_out[n] = ctrl_wr && wr_hi[HI_RING + NCH - 1 - n];
    assign bell_ack[n] = stat_wr && wr_hi[HI_BELL + NCH - 1 - n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      peer_q <= 1'b0;
    end else begin
      if (ctrl_wr) en_q <= wr_hi[HI_EN +: EN_W];
      peer_q <= peer_in_reset;
    end
  end

  assign te_f = flip(~tx_full);
  assign rf_f = flip(rx_full);
  assign gp_f = flip(bell_pend);

  assign stat_w = {gp_f, rf_f, te_f, 10'b0, peer_q, 9'b0};
  assign ctrl_w = {en_q, flip(ring_busy), 16'b0};

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NCH; n++) begin
      if (idx == IW'(IDX_TX + n)) rd_mux = tx_word[n];
      if (idx == IW'(IDX_RX + n)) rd_mux = rx_word[n];
    end
    if (idx == IW'(IDX_STAT)) rd_mux = stat_w;
    if (idx == IW'(IDX_CTRL)) rd_mux = ctrl_w;
  end

  assign cause = |((en_q[2*NCH +: NCH] & gp_f) |
                   (en_q[NCH +: NCH]   & rf_f) |
                   (en_q[0 +: NCH]     & te_f));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (sel && !wr) rdata <= aligned ? rd_mux : '0;
      irq <= cause;
    end
  end

  // R12: offsets past the control register read zero
  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
    sel && !wr && (idx > IW'(IDX_CTRL)) |=> rdata == '0);
  // R9: the interrupt never rises without some enable set the cycle before
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|en_q));
endmodule

// File: rtl/msg_unit.sv
module msg_unit
  import mu_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_sel,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [31:0]       a_wdata,
  output logic [31:0]       a_rdata,
  output logic              a_irq,
  input  logic              a_cpu_in_reset,
  input  logic              b_sel,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [31:0]       b_wdata,
  output logic [31:0]       b_rdata,
  output logic              b_irq,
  input  logic              b_cpu_in_reset
);
  logic [1:0]                   s_sel, s_wr, s_irq, s_peer;
  logic [ADDR_W-1:0]            s_addr  [2];
  logic [REG_W-1:0]             s_wdata [2];
  logic [REG_W-1:0]             s_rdata [2];
  logic [NCH-1:0]               tx_wr [2], rx_rd [2], full [2];
  logic [NCH-1:0]               ring [2], ack [2], pend [2];
  logic [NCH-1:0][REG_W-1:0]    word [2];

  assign s_sel      = {b_sel, a_sel};
  assign s_wr       = {b_wr, a_wr};
  assign s_peer     = {a_cpu_in_reset, b_cpu_in_reset};
  assign s_addr[0]  = a_addr;
  assign s_addr[1]  = b_addr;
  assign s_wdata[0] = a_wdata;
  assign s_wdata[1] = b_wdata;
  assign a_rdata    = s_rdata[0];
  assign b_rdata    = s_rdata[1];
  assign a_irq      = s_irq[0];
  assign b_irq      = s_irq[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    mu_side #(.ADDR_W(ADDR_W)) u_side (
      .clk           (clk),
      .rst           (rst),
      .sel           (s_sel[s]),
      .wr            (s_wr[s]),
      .addr          (s_addr[s]),
      .wr_hi         (s_wdata[s][31:16]),
      .rdata         (s_rdata[s]),
      .irq           (s_irq[s]),
      .peer_in_reset (s_peer[s]),
      .tx_wr         (tx_wr[s]),
      .tx_word       (word[s]),
      .tx_full       (full[s]),
      .rx_rd         (rx_rd[s]),
      .rx_word       (word[1-s]),
      .rx_full       (full[1-s]),
      .ring_out      (ring[s]),
      .ring_busy     (pend[s]),
      .bell_ack      (ack[s]),
      .bell_pend     (pend[1-s])
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
      mu_link #(.W(REG_W)) u_link (
        .clk   (clk),
        .rst   (rst),
        .wr    (tx_wr[s][n]),
        .wdata (s_wdata[s]),
        .rd    (rx_rd[1-s][n]),
        .word  (word[s][n]),
        .full  (full[s][n])
      );
      mu_bell u_bell (
        .clk  (clk),
        .rst  (rst),
        .ring (ring[s][n]),
        .ack  (ack[1-s][n]),
        .pend (pend[s][n])
      );
    end
  end
endmodule

// File: tb/msg_unit_bench.sv
module msg_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
  logic [5:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;
  logic        a_cpu_in_reset = 0, b_cpu_in_reset = 0;

  always #2 clk = ~clk;

  msg_unit u_msg_unit (
    .clk(clk), .rst(rst),
    .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq), .a_cpu_in_reset(a_cpu_in_reset),
    .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq), .b_cpu_in_reset(b_cpu_in_reset)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int          q_side [$];
  logic [31:0] q_exp  [$];
  string       q_tag  [$];
  logic drv_issue = 0, chk_now = 0;

  always @(posedge clk) chk_now <= drv_issue;

  // monitor: compares the registered read data one cycle after each read
  always @(negedge clk) begin
    if (chk_now && q_exp.size() > 0) begin
      int s; logic [31:0] e, act; string t;
      s = q_side.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      act = (s == 0) ? a_rdata : b_rdata;
      n_cmp++;
      if (act !== e) begin
        n_bad++;
        $display("FAIL %s side %0d act=%08h exp=%08h", t, s, act, e);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic clr_bus();
    a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0; drv_issue = 0;
  endtask

  task automatic set_side(input int s, input logic w, input logic [5:0] ad, input logic [31:0] d);
    if (s == 0) begin a_sel = 1; a_wr = w; a_addr = ad; a_wdata = d; end
    else        begin b_sel = 1; b_wr = w; b_addr = ad; b_wdata = d; end
  endtask

  task automatic idle();
    @(negedge clk); clr_bus();
  endtask

  task automatic wr_op(input int s, input logic [5:0] ad, input logic [31:0] d);
    @(negedge clk); clr_bus(); set_side(s, 1'b1, ad, d);
  endtask

  task automatic rd_op(input int s, input logic [5:0] ad, input logic [31:0] e, input string tag);
    @(negedge clk); clr_bus(); set_side(s, 1'b0, ad, 32'h0);
    drv_issue = 1;
    q_side.push_back(s); q_exp.push_back(e); q_tag.push_back(tag);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 a_irq", {31'b0, a_irq}, 32'h0);
    check("R1 b_irq", {31'b0, b_irq}, 32'h0);
    rd_op(0, 6'h20, 32'h00F00000, "R1 A status");
    rd_op(1, 6'h20, 32'h00F00000, "R1 B status");
    rd_op(0, 6'h24, 32'h00000000, "R1 A ctrl");
    rd_op(1, 6'h24, 32'h00000000, "R1 B ctrl");
    // R11 peer reset indication
    @(negedge clk); clr_bus(); b_cpu_in_reset = 1;
    rd_op(0, 6'h20, 32'h00F00200, "R11 A sees B reset");
    rd_op(1, 6'h20, 32'h00F00000, "R11 B unaffected");
    @(negedge clk); clr_bus(); b_cpu_in_reset = 0;
    // R2 A->B channel 1
    wr_op(0, 6'h04, 32'hDEAD0001);
    rd_op(1, 6'h20, 32'h04F00000, "R2 B receive-full 1");
    rd_op(0, 6'h20, 32'h00B00000, "R2 A transmit-empty 1");
    rd_op(0, 6'h04, 32'hDEAD0001, "R5 outbound readback");
    // R5 overwrite while full
    wr_op(0, 6'h04, 32'h12345678);
    rd_op(1, 6'h20, 32'h04F00000, "R5 flags kept");
    rd_op(0, 6'h20, 32'h00B00000, "R5 A flags kept");
    // R3 read drains
    rd_op(1, 6'h14, 32'h12345678, "R3 B reads word");
    rd_op(1, 6'h20, 32'h00F00000, "R3 B full cleared");
    rd_op(0, 6'h20, 32'h00F00000, "R3 A empty restored");
    // R4 write collides with read on channel 0
    wr_op(0, 6'h00, 32'hAAAA0000);
    @(negedge clk); clr_bus();
    set_side(0, 1'b1, 6'h00, 32'hBBBB0000);
    set_side(1, 1'b0, 6'h10, 32'h0);
    drv_issue = 1;
    q_side.push_back(1); q_exp.push_back(32'hAAAA0000); q_tag.push_back("R4 old word");
    rd_op(1, 6'h20, 32'h08F00000, "R4 B still full");
    rd_op(0, 6'h20, 32'h00700000, "R4 A still not empty");
    rd_op(1, 6'h10, 32'hBBBB0000, "R4 new word");
    rd_op(0, 6'h20, 32'h00F00000, "R4 A empty after drain");
    // R2/R3 B->A channel 3
    wr_op(1, 6'h0C, 32'h00000033);
    rd_op(0, 6'h20, 32'h01F00000, "R2 A receive-full 3");
    rd_op(1, 6'h20, 32'h00E00000, "R2 B transmit-empty 3");
    rd_op(0, 6'h1C, 32'h00000033, "R3 A reads word");
    rd_op(1, 6'h20, 32'h00F00000, "R3 B empty restored");
    // R6 doorbell channel 2 A->B
    wr_op(0, 6'h24, 32'h00020000);
    rd_op(0, 6'h24, 32'h00020000, "R6 request readback");
    rd_op(1, 6'h20, 32'h20F00000, "R6 B pending 2");
    wr_op(0, 6'h24, 32'h00000000);
    rd_op(0, 6'h24, 32'h00020000, "R6 zero does not withdraw");
    // R7 clearing rules
    wr_op(1, 6'h20, 32'h00000000);
    rd_op(1, 6'h20, 32'h20F00000, "R7 zero write ignored");
    wr_op(1, 6'h20, 32'h0FF00200);
    rd_op(1, 6'h20, 32'h20F00000, "R7 other bits ignored");
    wr_op(1, 6'h20, 32'h20000000);
    rd_op(1, 6'h20, 32'h00F00000, "R7 pending cleared");
    rd_op(0, 6'h24, 32'h00000000, "R7 request self-cleared");
    // R8 ring and clear in one cycle, channel 0
    wr_op(0, 6'h24, 32'h00080000);
    @(negedge clk); clr_bus();
    set_side(0, 1'b1, 6'h24, 32'h00080000);
    set_side(1, 1'b1, 6'h20, 32'h80000000);
    rd_op(1, 6'h20, 32'h80F00000, "R8 ring wins");
    rd_op(0, 6'h24, 32'h00080000, "R8 request kept");
    wr_op(1, 6'h20, 32'h80000000);
    rd_op(1, 6'h20, 32'h00F00000, "R8 later clear");
    // R10 control readback
    wr_op(0, 6'h24, 32'hFFF00000);
    rd_op(0, 6'h24, 32'hFFF00000, "R10 enables readback");
    wr_op(0, 6'h24, 32'h0000FFFF);
    rd_op(0, 6'h24, 32'h00000000, "R10 low bits read zero");
    // R9 transmit-empty interrupt on A, channel 0
    wr_op(0, 6'h24, 32'h00800000);
    idle(); idle();
    check("R9 a_irq transmit-empty", {31'b0, a_irq}, 32'h1);
    wr_op(0, 6'h00, 32'h00000055);
    idle(); idle();
    check("R9 a_irq drops on send", {31'b0, a_irq}, 32'h0);
    rd_op(1, 6'h10, 32'h00000055, "R3 B reads ch0");
    idle(); idle();
    check("R9 a_irq back on drain", {31'b0, a_irq}, 32'h1);
    wr_op(0, 6'h24, 32'h00000000);
    idle(); idle();
    check("R9 a_irq masked", {31'b0, a_irq}, 32'h0);
    // R9 receive-full interrupt on B, channel 2
    wr_op(1, 6'h24, 32'h02000000);
    idle(); idle();
    check("R9 b_irq idle", {31'b0, b_irq}, 32'h0);
    wr_op(0, 6'h08, 32'h00000077);
    idle(); idle();
    check("R9 b_irq receive-full", {31'b0, b_irq}, 32'h1);
    rd_op(1, 6'h18, 32'h00000077, "R3 B reads ch2");
    idle(); idle();
    check("R9 b_irq cleared", {31'b0, b_irq}, 32'h0);
    // R9 doorbell interrupt on B, channel 1
    wr_op(1, 6'h24, 32'h40000000);
    wr_op(0, 6'h24, 32'h00040000);
    idle(); idle();
    check("R9 b_irq doorbell", {31'b0, b_irq}, 32'h1);
    wr_op(1, 6'h20, 32'h40000000);
    idle(); idle();
    check("R9 b_irq doorbell acked", {31'b0, b_irq}, 32'h0);
    // R12 unmapped and misaligned
    rd_op(0, 6'h28, 32'h00000000, "R12 offset 0x28");
    rd_op(1, 6'h3C, 32'h00000000, "R12 offset 0x3C");
    rd_op(0, 6'h21, 32'h00000000, "R12 misaligned");
    idle(); idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule